// File: doc/BRIEF.md
# Host Interrupt Request Aggregator

This block gathers every condition that a host processor must be told about (FIFO service levels, FIFO error pulses, a command entry sitting in the output latch, mailbox requests and the CPU's freeze mode) and reduces them to one main interrupt line plus two dedicated service request lines, one per FIFO direction. It also presents a status word that the host reads to find out why it was interrupted.

Level conditions (FIFO service levels, command present, freeze level) follow their sources. Event conditions (overrun, underrun, the two mailbox requests and the freeze entry event) are held in sticky flags. A host read of the status word clears these flags. A separate enable bit masks each source except the freeze entry event. When DMA is off, a routing bit decides whether FIFO service requests join the main interrupt or stay on their own pins.

All inputs are sampled on the rising clock edge. Every output reflects the inputs sampled at the previous edge, so there is exactly one register stage from any input to any output.

Top module: `hirq_aggregator`

## Requirements
- R1: While reset is low, all state clears: at the first falling edge after a reset edge, `status` is 0 and `host_irq`, `in_req` and `out_req` are 0.
- R2: `status[0]` (input service) is 1 one cycle after `in_free >= in_thresh` is sampled, and 0 one cycle after it is false.
- R3: `status[1]` (output service) is 1 one cycle after `out_fill >= out_thresh` is sampled, and 0 otherwise.
- R4: An `in_ovr` pulse sets `status[2]`. The flag stays set until a cycle in which `stat_rd` is sampled high. It drives `host_irq` only while `irq_en[0]` is set.
- R5: An `out_udr` pulse sets `status[3]`, with the same clearing rule as R4. It drives `host_irq` only while `irq_en[1]` is set.
- R6: `status[4]` follows `cmd_pending` with one cycle of delay. It drives `host_irq` while `irq_en[2]` is set.
- R7: `mbox_out` sets `status[5]` and `mbox_in` sets `status[6]`. Both are sticky and cleared by a status read. They are gated into `host_irq` by `irq_en[3]` and `irq_en[4]` respectively.
- R8: `status[7]` follows the `freeze` level. A rising edge of `freeze` sets `status[8]`, which drives `host_irq` regardless of `irq_en`. A status read clears `status[8]`, while `status[7]` stays set until `freeze` falls.
- R9: `host_irq` is the OR of all enabled conditions in the current `status` word. It stays high while any one of them remains.
- R10: The FIFO requests are merged when `dma_en` is 0 and `route_merge` is 1. In that case `status[0]` and `status[1]` feed `host_irq`, gated by `irq_en[5]` and `irq_en[6]`, and `in_req` and `out_req` are 0. Otherwise `in_req` equals `status[0]`, `out_req` equals `status[1]`, and neither feeds `host_irq`.
- R11: If a set pulse for a sticky flag arrives in the same cycle as `stat_rd`, the flag is set afterwards, not cleared.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| in_free | input | CW | Free entries in the input FIFO |
| in_thresh | input | CW | Input FIFO service threshold |
| out_fill | input | CW | Filled entries in the output FIFO |
| out_thresh | input | CW | Output FIFO service threshold |
| in_ovr | input | 1 | Input FIFO overrun pulse |
| out_udr | input | 1 | Output FIFO underrun pulse |
| cmd_pending | input | 1 | Command entry present in output latch |
| mbox_out | input | 1 | CPU wrote the outbound mailbox |
| mbox_in | input | 1 | CPU emptied the inbound mailbox |
| freeze | input | 1 | CPU freeze mode level |
| dma_en | input | 1 | DMA enabled |
| route_merge | input | 1 | Merge FIFO requests onto main interrupt when DMA is off |
| irq_en | input | 7 | Per-source interrupt enables |
| stat_rd | input | 1 | Host reads the status word this cycle |
| host_irq | output | 1 | Main interrupt to host |
| in_req | output | 1 | Dedicated input FIFO service request |
| out_req | output | 1 | Dedicated output FIFO service request |
| status | output | 9 | Status word read by the host |

## Verification
The hardest state to reach from the ports is a freeze entry event that outlives the freeze level. To get there, the stimulus raises `freeze`, lowers it again without a status read, and then checks that `host_irq` stays high with only `status[8]` set. The reverse case is also covered: after a read clears the event, `status[7]` must stay set while `freeze` remains high. Coincident set and read is driven on purpose for the overrun flag. In addition, long random phases run under each combination of `dma_en` and `route_merge`, with status reads at random, so that both routing modes are checked against the cycle model.

// File: rtl/hirq_pkg.sv
// Package: shared constants for the host interrupt aggregator.
// Assumes: status word layout and enable indices are fixed; consumers
// use these names rather than literal bit numbers.
package hirq_pkg;
    // Status word bit positions (host decodes these)
    localparam int ST_IN_SVC   = 0;
    localparam int ST_OUT_SVC  = 1;
    localparam int ST_OVR      = 2;
    localparam int ST_UDR      = 3;
    localparam int ST_CMD      = 4;
    localparam int ST_MB_OUT   = 5;
    localparam int ST_MB_IN    = 6;
    localparam int ST_FRZ_LVL  = 7;
    localparam int ST_FRZ_EVT  = 8;
    localparam int ST_W        = 9;

    // Enable vector positions
    localparam int EN_OVR      = 0;
    localparam int EN_UDR      = 1;
    localparam int EN_CMD      = 2;
    localparam int EN_MB_OUT   = 3;
    localparam int EN_MB_IN    = 4;
    localparam int EN_IN_SVC   = 5;
    localparam int EN_OUT_SVC  = 6;
    localparam int EN_W        = 7;

    // Sticky bank slot order
    localparam int SK_OVR      = 0;
    localparam int SK_UDR      = 1;
    localparam int SK_MB_OUT   = 2;
    localparam int SK_MB_IN    = 3;
    localparam int SK_FRZ_EVT  = 4;
    localparam int SK_N        = 5;
endpackage

// File: rtl/hirq_thresh_cmp.sv
// Module: registered threshold comparator.
// Does: flags a FIFO level at or above its programmed threshold.
// Assumes: level and threshold share one unsigned width.
module hirq_thresh_cmp #(
    parameter int CW = 8
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic [CW-1:0] level,
    input  logic [CW-1:0] thresh,
    output logic          hit_q
);
    // Register the comparison result
    always_ff @(posedge clk) begin
        if (!rst_n) hit_q <= 1'b0;
        else        hit_q <= (level >= thresh);
    end
endmodule

// File: rtl/hirq_sticky_bank.sv
// Module: bank of sticky event flags.
// Does: each flag is set by its pulse and cleared by a shared clear strobe;
//       a set in the clear cycle wins.
// Assumes: clear is a single-cycle strobe from the host status read.
module hirq_sticky_bank #(
    parameter int N = 4
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic [N-1:0] set,
    input  logic         clr,
    output logic [N-1:0] flag_q
);
    for (genvar i = 0; i < N; i++) begin : g_flag
        // Hold, set or clear one flag
        always_ff @(posedge clk) begin
            if (!rst_n)      flag_q[i] <= 1'b0;
            else if (set[i]) flag_q[i] <= 1'b1;
            else if (clr)    flag_q[i] <= 1'b0;
        end
    end
endmodule

// File: rtl/hirq_route.sv
// Module: interrupt combiner and FIFO request router.
// Does: gates each status condition with its enable, ORs them into the main
//       interrupt, and steers FIFO service requests to the main line or pins.
// Assumes: all inputs come straight from registers (outputs are glitch-safe
//          only in that sense); freeze event is not maskable.
module hirq_route
    import hirq_pkg::*;
(
    input  logic [ST_W-1:0] st,
    input  logic [EN_W-1:0] en,
    input  logic            merge,
    output logic            host_irq,
    output logic            in_req,
    output logic            out_req
);
    logic err_src, msg_src, svc_src;

    // Combine enabled sources into the main interrupt
    always_comb begin
        err_src  = (st[ST_OVR] & en[EN_OVR]) | (st[ST_UDR] & en[EN_UDR]);
        msg_src  = (st[ST_CMD] & en[EN_CMD])
                 | (st[ST_MB_OUT] & en[EN_MB_OUT])
                 | (st[ST_MB_IN] & en[EN_MB_IN]);
        svc_src  = merge & ((st[ST_IN_SVC] & en[EN_IN_SVC])
                          | (st[ST_OUT_SVC] & en[EN_OUT_SVC]));
        host_irq = err_src | msg_src | svc_src | st[ST_FRZ_EVT];
    end

    // Drive dedicated pins when not merged
    always_comb begin
        in_req  = st[ST_IN_SVC]  & ~merge;
        out_req = st[ST_OUT_SVC] & ~merge;
    end
endmodule

// File: rtl/hirq_aggregator.sv
// Module: host interrupt request aggregator (top).
// Does: samples FIFO levels, error pulses, command/mailbox events and the
//       freeze level; keeps a status word and drives the host interrupt and
//       per-FIFO request lines one cycle after the inputs are sampled.
// Assumes: pulses are single-cycle, stat_rd is one cycle per host read.
module hirq_aggregator
    import hirq_pkg::*;
#(
    parameter int DEPTH = 128,
    parameter int CW    = $clog2(DEPTH + 1)
) (
    input  logic            clk,
    input  logic            rst_n,
    input  logic [CW-1:0]   in_free,
    input  logic [CW-1:0]   in_thresh,
    input  logic [CW-1:0]   out_fill,
    input  logic [CW-1:0]   out_thresh,
    input  logic            in_ovr,
    input  logic            out_udr,
    input  logic            cmd_pending,
    input  logic            mbox_out,
    input  logic            mbox_in,
    input  logic            freeze,
    input  logic            dma_en,
    input  logic            route_merge,
    input  logic [EN_W-1:0] irq_en,
    input  logic            stat_rd,
    output logic            host_irq,
    output logic            in_req,
    output logic            out_req,
    output logic [ST_W-1:0] status
);
    localparam int NCMP = 2;

    logic [NCMP-1:0]   cmp_hit;
    logic [CW-1:0]     cmp_lvl [NCMP];
    logic [CW-1:0]     cmp_thr [NCMP];
    logic [SK_N-1:0]   sk_set;
    logic [SK_N-1:0]   sk_flag;
    logic              cmd_q, frz_q, merge_q;
    logic [EN_W-1:0]   en_q;

    // Map FIFO levels to comparator slots (0 = input, 1 = output)
    always_comb begin
        cmp_lvl[0] = in_free;
        cmp_thr[0] = in_thresh;
        cmp_lvl[1] = out_fill;
        cmp_thr[1] = out_thresh;
    end

    for (genvar c = 0; c < NCMP; c++) begin : g_cmp
        hirq_thresh_cmp #(.CW(CW)) u_cmp (
            .clk    (clk),
            .rst_n  (rst_n),
            .level  (cmp_lvl[c]),
            .thresh (cmp_thr[c]),
            .hit_q  (cmp_hit[c])
        );
    end

    // Build sticky set vector; freeze event is its rising edge
    always_comb begin
        sk_set             = '0;
        sk_set[SK_OVR]     = in_ovr;
        sk_set[SK_UDR]     = out_udr;
        sk_set[SK_MB_OUT]  = mbox_out;
        sk_set[SK_MB_IN]   = mbox_in;
        sk_set[SK_FRZ_EVT] = freeze & ~frz_q;
    end

    hirq_sticky_bank #(.N(SK_N)) u_sticky (
        .clk    (clk),
        .rst_n  (rst_n),
        .set    (sk_set),
        .clr    (stat_rd),
        .flag_q (sk_flag)
    );

    // Register level conditions and control bits
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            cmd_q   <= 1'b0;
            frz_q   <= 1'b0;
            merge_q <= 1'b0;
            en_q    <= '0;
        end else begin
            cmd_q   <= cmd_pending;
            frz_q   <= freeze;
            merge_q <= ~dma_en & route_merge;
            en_q    <= irq_en;
        end
    end

    // Assemble the status word
    always_comb begin
        status              = '0;
        status[ST_IN_SVC]   = cmp_hit[0];
        status[ST_OUT_SVC]  = cmp_hit[1];
        status[ST_OVR]      = sk_flag[SK_OVR];
        status[ST_UDR]      = sk_flag[SK_UDR];
        status[ST_CMD]      = cmd_q;
        status[ST_MB_OUT]   = sk_flag[SK_MB_OUT];
        status[ST_MB_IN]    = sk_flag[SK_MB_IN];
        status[ST_FRZ_LVL]  = frz_q;
        status[ST_FRZ_EVT]  = sk_flag[SK_FRZ_EVT];
    end

    hirq_route u_route (
        .st       (status),
        .en       (en_q),
        .merge    (merge_q),
        .host_irq (host_irq),
        .in_req   (in_req),
        .out_req  (out_req)
    );
endmodule

// File: rtl/hirq_aggregator_chk.sv
// Module: assertion checker for hirq_aggregator, bound to every instance.
// Assumes: observes ports only.
module hirq_aggregator_chk (
    input logic       clk,
    input logic       rst_n,
    input logic       in_ovr,
    input logic       freeze,
    input logic       stat_rd,
    input logic       host_irq,
    input logic       in_req,
    input logic       out_req,
    input logic [8:0] status
);
    p_reset_quiet_r1: assert property (@(posedge clk)
        !rst_n |=> (status == '0 && !host_irq && !in_req && !out_req));

    p_ovr_sets_r4: assert property (@(posedge clk) disable iff (!rst_n)
        in_ovr |=> status[2]);

    p_ovr_holds_r4: assert property (@(posedge clk) disable iff (!rst_n)
        (status[2] && !stat_rd) |=> status[2]);

    p_ovr_clears_r11: assert property (@(posedge clk) disable iff (!rst_n)
        (stat_rd && !in_ovr) |=> !status[2]);

    p_frz_rise_irq_r8: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(freeze) |=> (host_irq && status[8]));

    p_frz_level_r8: assert property (@(posedge clk) disable iff (!rst_n)
        freeze |=> status[7]);

    p_irq_has_source_r9: assert property (@(posedge clk) disable iff (!rst_n)
        host_irq |-> (status != '0));

    p_pins_follow_r10: assert property (@(posedge clk) disable iff (!rst_n)
        (in_req |-> status[0]) and (out_req |-> status[1]));
endmodule

bind hirq_aggregator hirq_aggregator_chk u_chk (
    .clk      (clk),
    .rst_n    (rst_n),
    .in_ovr   (in_ovr),
    .freeze   (freeze),
    .stat_rd  (stat_rd),
    .host_irq (host_irq),
    .in_req   (in_req),
    .out_req  (out_req),
    .status   (status)
);

// File: tb/hirq_aggregator_bench.sv
// Bench: behavioural cycle model compared on every falling edge,
// plus directed checks for freeze, routing and coincident read cases.
module hirq_aggregator_bench;
    localparam int CW = 8;

    logic         clk = 1'b0;
    logic         rst_n = 1'b0;
    logic [CW-1:0] in_free = '0, in_thresh = '0, out_fill = '0, out_thresh = '0;
    logic         in_ovr = 0, out_udr = 0, cmd_pending = 0, mbox_out = 0, mbox_in = 0;
    logic         freeze = 0, dma_en = 0, route_merge = 0, stat_rd = 0;
    logic [6:0]   irq_en = '0;
    logic         host_irq, in_req, out_req;
    logic [8:0]   status;

    int n_checks = 0;
    int n_fail   = 0;
    bit done     = 0;

    always #4 clk = ~clk;   // 125 MHz

    hirq_aggregator u_hirq_aggregator (
        .clk(clk), .rst_n(rst_n),
        .in_free(in_free), .in_thresh(in_thresh),
        .out_fill(out_fill), .out_thresh(out_thresh),
        .in_ovr(in_ovr), .out_udr(out_udr), .cmd_pending(cmd_pending),
        .mbox_out(mbox_out), .mbox_in(mbox_in), .freeze(freeze),
        .dma_en(dma_en), .route_merge(route_merge), .irq_en(irq_en),
        .stat_rd(stat_rd),
        .host_irq(host_irq), .in_req(in_req), .out_req(out_req),
        .status(status)
    );

    // ---------------- reference model ----------------
    bit m_isvc, m_osvc, m_ovr, m_udr, m_cmd, m_mbo, m_mbi, m_frz, m_fev, m_mrg;
    bit [6:0] m_en;

    always @(posedge clk) begin
        if (!rst_n) begin
            {m_isvc, m_osvc, m_ovr, m_udr, m_cmd, m_mbo, m_mbi, m_frz, m_fev, m_mrg} = '0;
            m_en = '0;
        end else begin
            m_isvc = (in_free >= in_thresh);
            m_osvc = (out_fill >= out_thresh);
            m_ovr  = in_ovr   || (m_ovr && !stat_rd);
            m_udr  = out_udr  || (m_udr && !stat_rd);
            m_mbo  = mbox_out || (m_mbo && !stat_rd);
            m_mbi  = mbox_in  || (m_mbi && !stat_rd);
            m_fev  = (freeze && !m_frz) || (m_fev && !stat_rd);
            m_frz  = freeze;
            m_cmd  = cmd_pending;
            m_mrg  = !dma_en && route_merge;
            m_en   = irq_en;
        end
    end

    function automatic logic [8:0] exp_status();
        return {m_fev, m_frz, m_mbi, m_mbo, m_cmd, m_udr, m_ovr, m_osvc, m_isvc};
    endfunction

    function automatic logic exp_irq();
        return (m_ovr && m_en[0]) || (m_udr && m_en[1]) || (m_cmd && m_en[2])
            || (m_mbo && m_en[3]) || (m_mbi && m_en[4]) || m_fev
            || (m_mrg && ((m_isvc && m_en[5]) || (m_osvc && m_en[6])));
    endfunction

    task automatic check(input string req, input int act, input int exp);
        n_checks++;
        if (act != exp) begin
            n_fail++;
            $display("FAIL %s: actual %0h expected %0h at %0t", req, act, exp, $time);
        end
    endtask

    // Compare every output with the model on each falling edge
    always @(negedge clk) begin
        if (rst_n && !done) begin
            check("R2/R3/R4/R5/R6/R7/R8 status", status, exp_status());
            check("R9 host_irq", host_irq, exp_irq());
            check("R10 in_req", in_req, m_isvc && !m_mrg);
            check("R10 out_req", out_req, m_osvc && !m_mrg);
        end
    end

    task automatic clear_pulses();
        in_ovr = 0; out_udr = 0; mbox_out = 0; mbox_in = 0; stat_rd = 0;
    endtask

    task automatic step(input int n);
        for (int i = 0; i < n; i++) @(negedge clk);
    endtask

    // Random phase under one routing setting
    task automatic rand_phase(input bit d, input bit r, input int cycles);
        dma_en = d; route_merge = r;
        for (int i = 0; i < cycles; i++) begin
            @(negedge clk);
            in_free     = 8'($urandom_range(0, 128));
            in_thresh   = 8'($urandom_range(0, 128));
            out_fill    = 8'($urandom_range(0, 128));
            out_thresh  = 8'($urandom_range(0, 128));
            in_ovr      = ($urandom_range(0, 15) == 0);
            out_udr     = ($urandom_range(0, 15) == 0);
            mbox_out    = ($urandom_range(0, 15) == 0);
            mbox_in     = ($urandom_range(0, 15) == 0);
            stat_rd     = ($urandom_range(0, 7) == 0);
            cmd_pending = ($urandom_range(0, 3) == 0);
            if ($urandom_range(0, 31) == 0) freeze = ~freeze;
            if ($urandom_range(0, 63) == 0) irq_en = 7'($urandom());
        end
        @(negedge clk); clear_pulses();
    endtask

    initial begin
        // R1: reset state
        rst_n = 0; irq_en = '1;
        in_free = 5; in_thresh = 3; cmd_pending = 1; freeze = 1;
        step(3);
        check("R1 status in reset", status, 0);
        check("R1 host_irq in reset", host_irq, 0);
        check("R1 pins in reset", {in_req, out_req}, 0);
        cmd_pending = 0; freeze = 0; in_free = 0; in_thresh = 1;
        rst_n = 1;
        step(2);

        // R2/R3: threshold boundary, equal counts as reached
        in_free = 10; in_thresh = 10; out_fill = 9; out_thresh = 10;
        dma_en = 1; route_merge = 0;
        step(1);
        check("R2 free == thresh", status[0], 1);
        check("R3 fill below thresh", status[1], 0);
        out_fill = 10;
        step(1);
        check("R3 fill == thresh", status[1], 1);
        check("R10 out_req on pin with dma", out_req, 1);

        // R10: merged routing moves requests to host_irq
        dma_en = 0; route_merge = 1; irq_en = 7'b1100000;
        step(1);
        check("R10 pins low when merged", {in_req, out_req}, 0);
        check("R10 merged svc drives irq", host_irq, 1);
        in_free = 0; out_fill = 0;
        step(1);
        check("R9 irq drops with no source", host_irq, 0);

        // R4/R11: overrun coincident with status read stays set
        irq_en = 7'b0000000;
        in_ovr = 1; stat_rd = 1;
        step(1); clear_pulses();
        check("R11 set wins over read", status[2], 1);
        check("R4 masked overrun no irq", host_irq, 0);
        irq_en[0] = 1;
        step(1);
        check("R4 enabled overrun irq", host_irq, 1);
        stat_rd = 1; step(1); clear_pulses();
        check("R4 read clears overrun", status[2], 0);

        // R5/R7: underrun and mailbox stickiness
        out_udr = 1; mbox_out = 1; mbox_in = 1; irq_en = 7'b0011010;
        step(1); clear_pulses();
        step(3);
        check("R5 underrun held", status[3], 1);
        check("R7 mailbox flags held", status[6:5], 2'b11);
        stat_rd = 1; step(1); clear_pulses();
        check("R7 read clears mailboxes", status[6:5], 0);

        // R6: command present level
        irq_en = 7'b0000100; cmd_pending = 1;
        step(1);
        check("R6 command irq", {status[4], host_irq}, 2'b11);
        cmd_pending = 0; step(1);
        check("R6 command gone", host_irq, 0);

        // R8: freeze event outlives level; read clears event, not level
        irq_en = '0; freeze = 1;
        step(1);
        check("R8 freeze raises irq", {status[8], status[7], host_irq}, 3'b111);
        freeze = 0; step(2);
        check("R8 event stays after level drops", {status[8], status[7], host_irq}, 3'b101);
        stat_rd = 1; step(1); clear_pulses();
        check("R8 read clears event", host_irq, 0);
        freeze = 1; step(1);
        stat_rd = 1; step(1); clear_pulses();
        check("R8 level persists after read", {status[8], status[7]}, 2'b01);
        freeze = 0; step(1);

        // Random phases under each routing mode
        irq_en = '1;
        rand_phase(0, 0, 1500);
        rand_phase(0, 1, 1500);
        rand_phase(1, 1, 1500);
        rand_phase(1, 0, 1500);

        done = 1;
        $display("  [TB] %0d tests run, %0d failed", n_checks, n_fail);
        $finish;
    end

    // Watchdog
    initial begin
        #(8 * 150000);
        n_checks++; n_fail++;
        $display("FAIL watchdog: actual timeout expected completion");
        $display("  [TB] %0d tests run, %0d failed", n_checks, n_fail);
        $finish;
    end
endmodule